// File: doc/BRIEF.md
# Write-Leveling Phase Retry Sequencer

This block drives the supplementary write-leveling retry loop over a range of byte lanes. It visits each lane in the range whose bit in the active mask is set. For each such lane it reads the lane's leveling register over a simple request/acknowledge register port and keeps that word. It then asks an external pass/fail checker for a verdict. While the checker keeps reporting failure, the block rewrites the 3-bit phase field of the register with a fixed series of trial values taken from the saved phase: first two below it, then two above it, then four above it. Each trial is written only when its own range guard allows it.

A pass ends the lane at once. A failure after the third trial exhausts the lane and marks the whole run as failed, but the remaining lanes are still processed. When the last lane is finished, a one-cycle done pulse reports the overall result. Busy stays high from the cycle after the start pulse until the done cycle. Pattern generation and the checker are outside this block.

Top module: `wl_phase_retry_seq`

## Requirements
- R1: After reset, busy, done and fail are low, and neither reg_req nor chk_req is raised until a start pulse.
- R2: Lanes are visited in ascending order from lane_first up to lane_end-1, and never at or beyond LANES. A lane whose bit in lane_mask is 0 gets no register access and no check. The range and mask are sampled on the start cycle.
- R3: The first transaction for a visited lane is a read (reg_we=0) of that lane. The saved phase is bits [8:6] of the returned word.
- R4: After the read, a check is requested for the lane. A pass (chk_pass=1 with chk_ack) ends the lane with no further write, and the next lane follows.
- R5: After the first failed check, if the saved phase is 2 or more, the lane register is written with the saved word with bits [8:6] replaced by phase-2.
- R6: After the first failed check, if the saved phase is 1, the written word is the saved word with the bits under mask 0x1DF cleared. If the saved phase is 0, nothing is written and the next check follows directly.
- R7: After the second failed check, if the saved phase is at most 5, the saved word with bits [8:6] = phase+2 is written. Otherwise nothing is written and the next check follows.
- R8: After the third failed check, if the saved phase is at most 3, the saved word with bits [8:6] = phase+4 is written. Otherwise nothing is written and the next check follows.
- R9: A failed fourth check exhausts the lane. fail is then high at done, and the lanes after it are still processed. fail is cleared when a new run starts.
- R10: After the last lane, done is high for exactly one cycle while busy is high, and busy is low in the following cycle. With no failed lane, fail is 0 at done. An empty range gives done with fail 0 and no transactions.
- R11: Only one of reg_req and chk_req is high at a time. Each request, with its lane, write flag and write data, is held stable until its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle run start, taken while idle |
| lane_first | input | LW | First lane of the range |
| lane_end | input | LW | One past the last lane of the range |
| lane_mask | input | LANES | Lane-active mask, bit n for lane n |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_lane | output | LW | Lane addressed by the access |
| reg_wdata | output | REG_W | Write data |
| reg_ack | input | 1 | Access acknowledge, rdata valid with it |
| reg_rdata | input | REG_W | Read data |
| chk_req | output | 1 | Check request |
| chk_lane | output | LW | Lane being checked |
| chk_ack | input | 1 | Check acknowledge |
| chk_pass | input | 1 | Check verdict, valid with chk_ack |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Some lane exhausted its trials |

## Verification
A check acknowledge can land in the same cycle as the decision to advance to the next lane, and also in the same cycle as the choice between a trial write and a direct re-check. The second case arises when a range guard suppresses the write, so a new check request follows back to back with the old one. The bench provokes this with saved phases 0, 6 and 7 against a checker that never passes, and with random acknowledge delays of zero to two cycles. Every accepted transaction is compared in order against a list the bench builds from the requirements. A missing or extra write, or a wrong lane, shows up as a mismatch at that position.

// File: rtl/wl_retry_pkg.sv
package wl_retry_pkg;
  // position and width of the phase field inside a lane leveling word
  localparam int PH_LSB = 6;
  localparam int PH_W   = 3;
  // bits cleared by the first trial when the saved phase is 1
  localparam int CLR_ONE_MASK = 'h1DF;
  // number of trial offsets after the initial check
  localparam int TRIALS = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SCAN,
    S_READ,
    S_CHECK,
    S_WRITE,
    S_DONE
  } seq_state_e;
endpackage

// File: rtl/wl_trial_calc.sv
module wl_trial_calc
  import wl_retry_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic [REG_W-1:0] saved_word,
  input  logic [1:0]       trial_no,
  output logic             wr_en,
  output logic [REG_W-1:0] wr_word
);
  localparam logic [REG_W-1:0] CLR_MASK = REG_W'(CLR_ONE_MASK);

  function automatic logic [PH_W-1:0] phase_of(input logic [REG_W-1:0] w);
    return w[PH_LSB +: PH_W];
  endfunction

  function automatic logic [REG_W-1:0] with_phase(input logic [REG_W-1:0] w,
                                                  input logic [PH_W-1:0] p);
    logic [REG_W-1:0] r;
    r = w;
    r[PH_LSB +: PH_W] = p;
    return r;
  endfunction

  logic [PH_W-1:0] ph;
  assign ph = phase_of(saved_word);

  always_comb begin
    wr_en   = 1'b0;
    wr_word = saved_word;
    unique case (trial_no)
      2'd1: begin
        if (ph > PH_W'(1)) begin
          wr_en   = 1'b1;
          wr_word = with_phase(saved_word, ph - PH_W'(2));
        end else if (ph == PH_W'(1)) begin
          wr_en   = 1'b1;
          wr_word = saved_word & ~CLR_MASK;
        end
      end
      2'd2: begin
        if (ph <= PH_W'(5)) begin
          wr_en   = 1'b1;
          wr_word = with_phase(saved_word, ph + PH_W'(2));
        end
      end
      2'd3: begin
        if (ph <= PH_W'(3)) begin
          wr_en   = 1'b1;
          wr_word = with_phase(saved_word, ph + PH_W'(4));
        end
      end
      default: begin
        wr_en = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/wl_lane_cursor.sv
module wl_lane_cursor #(
  parameter int LANES = 9,
  parameter int LW    = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LW-1:0]    first_in,
  input  logic [LW-1:0]    end_in,
  input  logic [LANES-1:0] mask_in,
  input  logic             adv,
  output logic [LW-1:0]    lane,
  output logic             at_end,
  output logic             lane_on
);
  logic [LW-1:0]    end_q;
  logic [LANES-1:0] mask_q;
  logic [LANES-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane   <= '0;
      end_q  <= '0;
      mask_q <= '0;
    end else if (load) begin
      lane   <= first_in;
      end_q  <= end_in;
      mask_q <= mask_in;
    end else if (adv) begin
      lane <= lane + LW'(1);
    end
  end

  // one-hot decode of the cursor against the mask; lanes beyond LANES read 0
  for (genvar g = 0; g < LANES; g++) begin : g_hit
    assign hit[g] = mask_q[g] && (lane == LW'(g));
  end

  assign lane_on = |hit;
  assign at_end  = (lane >= end_q) || (lane >= LW'(LANES));
endmodule

// File: rtl/wl_retry_ctrl.sv
module wl_retry_ctrl
  import wl_retry_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             at_end,
  input  logic             lane_on,
  input  logic             reg_ack,
  input  logic [REG_W-1:0] reg_rdata,
  input  logic             chk_ack,
  input  logic             chk_pass,
  input  logic             trial_wr_en,
  output logic             cur_load,
  output logic             cur_adv,
  output logic [REG_W-1:0] saved_word,
  output logic [1:0]       trial_no,
  output logic             reg_req,
  output logic             reg_we,
  output logic             chk_req,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic             ev_read_done,
  output logic             ev_check_fail,
  output logic             ev_exhaust
);
  seq_state_e state, state_nx;
  logic [1:0] step_q;
  logic       fail_q;
  logic       ev_pass;

  assign ev_read_done  = (state == S_READ)  && reg_ack;
  assign ev_pass       = (state == S_CHECK) && chk_ack && chk_pass;
  assign ev_check_fail = (state == S_CHECK) && chk_ack && !chk_pass;
  assign ev_exhaust    = ev_check_fail && (step_q == 2'(TRIALS));

  // in CHECK the calculator looks one trial ahead; in WRITE it uses the current one
  assign trial_no = (state == S_WRITE) ? step_q : step_q + 2'd1;

  assign cur_load = (state == S_IDLE) && start;
  assign cur_adv  = ((state == S_SCAN) && !at_end && !lane_on) || ev_pass || ev_exhaust;

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:  if (start) state_nx = S_SCAN;
      S_SCAN: begin
        if (at_end)       state_nx = S_DONE;
        else if (lane_on) state_nx = S_READ;
      end
      S_READ:  if (reg_ack) state_nx = S_CHECK;
      S_CHECK: begin
        if (ev_pass || ev_exhaust) state_nx = S_SCAN;
        else if (ev_check_fail)    state_nx = trial_wr_en ? S_WRITE : S_CHECK;
      end
      S_WRITE: if (reg_ack) state_nx = S_CHECK;
      S_DONE:  state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      step_q     <= '0;
      fail_q     <= 1'b0;
      saved_word <= '0;
    end else begin
      state <= state_nx;
      if (cur_load) fail_q <= 1'b0;
      if (ev_exhaust) fail_q <= 1'b1;
      if (ev_read_done) begin
        saved_word <= reg_rdata;
        step_q     <= '0;
      end else if (ev_check_fail && !ev_exhaust) begin
        step_q <= step_q + 2'd1;
      end
    end
  end

  assign reg_req = (state == S_READ) || (state == S_WRITE);
  assign reg_we  = (state == S_WRITE);
  assign chk_req = (state == S_CHECK);
  assign busy    = (state != S_IDLE);
  assign done    = (state == S_DONE);
  assign fail    = fail_q;
endmodule

// File: rtl/wl_phase_retry_seq.sv
module wl_phase_retry_seq
  import wl_retry_pkg::*;
#(
  parameter int LANES = 9,
  parameter int REG_W = 32,
  parameter int LW    = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LW-1:0]    lane_first,
  input  logic [LW-1:0]    lane_end,
  input  logic [LANES-1:0] lane_mask,
  output logic             reg_req,
  output logic             reg_we,
  output logic [LW-1:0]    reg_lane,
  output logic [REG_W-1:0] reg_wdata,
  input  logic             reg_ack,
  input  logic [REG_W-1:0] reg_rdata,
  output logic             chk_req,
  output logic [LW-1:0]    chk_lane,
  input  logic             chk_ack,
  input  logic             chk_pass,
  output logic             busy,
  output logic             done,
  output logic             fail
);
  logic             cur_load, cur_adv, at_end, lane_on;
  logic [LW-1:0]    lane;
  logic [REG_W-1:0] saved_word;
  logic [1:0]       trial_no;
  logic             trial_wr_en;
  logic [REG_W-1:0] trial_word;
  logic             ev_read_done, ev_check_fail, ev_exhaust;

  wl_lane_cursor #(.LANES(LANES), .LW(LW)) u_cursor (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cur_load),
    .first_in (lane_first),
    .end_in   (lane_end),
    .mask_in  (lane_mask),
    .adv      (cur_adv),
    .lane     (lane),
    .at_end   (at_end),
    .lane_on  (lane_on)
  );

  wl_trial_calc #(.REG_W(REG_W)) u_trial (
    .saved_word (saved_word),
    .trial_no   (trial_no),
    .wr_en      (trial_wr_en),
    .wr_word    (trial_word)
  );

  wl_retry_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .at_end        (at_end),
    .lane_on       (lane_on),
    .reg_ack       (reg_ack),
    .reg_rdata     (reg_rdata),
    .chk_ack       (chk_ack),
    .chk_pass      (chk_pass),
    .trial_wr_en   (trial_wr_en),
    .cur_load      (cur_load),
    .cur_adv       (cur_adv),
    .saved_word    (saved_word),
    .trial_no      (trial_no),
    .reg_req       (reg_req),
    .reg_we        (reg_we),
    .chk_req       (chk_req),
    .busy          (busy),
    .done          (done),
    .fail          (fail),
    .ev_read_done  (ev_read_done),
    .ev_check_fail (ev_check_fail),
    .ev_exhaust    (ev_exhaust)
  );

  assign reg_lane  = lane;
  assign chk_lane  = lane;
  assign reg_wdata = reg_we ? trial_word : '0;
endmodule

// File: rtl/wl_retry_seq_chk.sv
module wl_retry_seq_chk #(
  parameter int REG_W = 32,
  parameter int LW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_req,
  input logic             reg_we,
  input logic [LW-1:0]    reg_lane,
  input logic [REG_W-1:0] reg_wdata,
  input logic             reg_ack,
  input logic             chk_req,
  input logic [LW-1:0]    chk_lane,
  input logic             chk_ack,
  input logic             chk_pass,
  input logic             busy,
  input logic             done,
  input logic             fail,
  input logic             ev_read_done,
  input logic             ev_exhaust
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!reg_req && !chk_req));

  p_reg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_we) && $stable(reg_lane) && $stable(reg_wdata)));

  p_chk_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req && !chk_ack) |=> (chk_req && $stable(chk_lane)));

  p_one_txn_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_req && chk_req));

  p_read_then_check_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_read_done |=> (chk_req && !reg_req));

  p_pass_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req && chk_ack && chk_pass) |=> !(reg_req && reg_we));

  p_write_after_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(reg_req) && reg_we) |-> $past(chk_req && chk_ack && !chk_pass));

  p_exhaust_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_exhaust |=> fail);

  p_fail_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !fail);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_done_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
endmodule

bind wl_phase_retry_seq wl_retry_seq_chk #(.REG_W(REG_W), .LW(LW)) u_retry_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_req      (reg_req),
  .reg_we       (reg_we),
  .reg_lane     (reg_lane),
  .reg_wdata    (reg_wdata),
  .reg_ack      (reg_ack),
  .chk_req      (chk_req),
  .chk_lane     (chk_lane),
  .chk_ack      (chk_ack),
  .chk_pass     (chk_pass),
  .busy         (busy),
  .done         (done),
  .fail         (fail),
  .ev_read_done (ev_read_done),
  .ev_exhaust   (ev_exhaust)
);

// File: tb/test_wl_phase_retry_seq.sv
`timescale 1ns/1ps
module test_wl_phase_retry_seq;
  localparam int LANES = 9;
  localparam int REG_W = 32;
  localparam int LW    = $clog2(LANES + 1);
  localparam int MAXE  = 128;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [LW-1:0]    lane_first = '0;
  logic [LW-1:0]    lane_end = '0;
  logic [LANES-1:0] lane_mask = '0;
  logic             reg_req, reg_we, chk_req, busy, done, fail;
  logic [LW-1:0]    reg_lane, chk_lane;
  logic [REG_W-1:0] reg_wdata;
  logic             reg_ack = 1'b0;
  logic [REG_W-1:0] reg_rdata = '0;
  logic             chk_ack = 1'b0;
  logic             chk_pass = 1'b0;

  always #10 clk = ~clk;

  wl_phase_retry_seq #(.LANES(LANES), .REG_W(REG_W)) i_wl_phase_retry_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_first(lane_first),
    .lane_end(lane_end), .lane_mask(lane_mask), .reg_req(reg_req),
    .reg_we(reg_we), .reg_lane(reg_lane), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata), .chk_req(chk_req),
    .chk_lane(chk_lane), .chk_ack(chk_ack), .chk_pass(chk_pass),
    .busy(busy), .done(done), .fail(fail)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // PHY register model and per-lane checker behaviour (pass at check k, 4 = never)
  logic [REG_W-1:0] regs [LANES];
  int               pass_at [LANES];

  // expected transaction list: kind 0 read, 1 write, 2 check
  int               e_kind [MAXE];
  int               e_lane [MAXE];
  logic [REG_W-1:0] e_data [MAXE];
  bit               e_pass [MAXE];
  string            e_tag  [MAXE];
  int               e_n, e_idx;
  bit               e_fail;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // trial rule restated as arithmetic on the whole word
  function automatic bit bench_trial(input logic [REG_W-1:0] w, input int s,
                                     output logic [REG_W-1:0] d, output string tag);
    int p;
    p = int'((w >> 6) & 32'd7);
    d = w;
    tag = "R5";
    if (s == 1) begin
      if (p >= 2) begin d = w - (32'd2 << 6); tag = "R5"; return 1; end
      if (p == 1) begin d = w & 32'hFFFF_FE20; tag = "R6"; return 1; end
      return 0;
    end
    if (s == 2) begin
      tag = "R7";
      if (p < 6) begin d = w + (32'd2 << 6); return 1; end
      return 0;
    end
    tag = "R8";
    if (p < 4) begin d = w + (32'd4 << 6); return 1; end
    return 0;
  endfunction

  task automatic push(input int k, input int l, input logic [REG_W-1:0] d,
                      input bit p, input string tag);
    e_kind[e_n] = k; e_lane[e_n] = l; e_data[e_n] = d;
    e_pass[e_n] = p; e_tag[e_n] = tag;
    e_n++;
  endtask

  task automatic plan_run(input int first, input int last_x, input logic [LANES-1:0] m);
    logic [REG_W-1:0] d;
    string tg;
    bit en;
    e_n = 0; e_idx = 0; e_fail = 0;
    for (int l = first; l < last_x && l < LANES; l++) begin
      if (m[l]) begin
        push(0, l, '0, 0, "R3");
        for (int k = 0; k < 4; k++) begin
          push(2, l, '0, k == pass_at[l], "R4");
          if (k == pass_at[l]) break;
          if (k == 3) begin e_fail = 1; break; end
          en = bench_trial(regs[l], k + 1, d, tg);
          if (en) push(1, l, d, 0, tg);
        end
      end
    end
  endtask

  // responder: acks one transaction at a time after a random 0..2 cycle delay
  bit pend = 0;
  int dly = 0;
  int pend_lane = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (reg_ack || chk_ack) begin
        reg_ack = 1'b0; chk_ack = 1'b0; pend = 0;
      end
      if (reg_req || chk_req) begin
        if (!pend) begin
          pend = 1; dly = int'($urandom % 3);
          pend_lane = reg_req ? int'(reg_lane) : int'(chk_lane);
        end
        if (dly == 0) begin
          int l;
          int k;
          l = reg_req ? int'(reg_lane) : int'(chk_lane);
          k = reg_req ? (reg_we ? 1 : 0) : 2;
          check(l == pend_lane, "R11", "lane held until ack", l, pend_lane);
          if (e_idx >= e_n) begin
            check(0, "R2", "unexpected transaction kind", k, 99);
            chk_pass = 1'b1;
          end else begin
            check(l == e_lane[e_idx], "R2", "lane order", l, e_lane[e_idx]);
            check(k == e_kind[e_idx], e_tag[e_idx], "transaction kind", k, e_kind[e_idx]);
            if (k == 1 && e_kind[e_idx] == 1)
              check(reg_wdata == e_data[e_idx], e_tag[e_idx], "write data",
                    reg_wdata, e_data[e_idx]);
            chk_pass = e_pass[e_idx];
            e_idx++;
          end
          if (k == 0 && l < LANES) reg_rdata = regs[l];
          if (k == 1 && l < LANES) regs[l] = reg_wdata;
          if (k == 2) chk_ack = 1'b1; else reg_ack = 1'b1;
        end else begin
          dly--;
        end
      end
    end
  end

  task automatic run(input int first, input int last_x, input logic [LANES-1:0] m);
    int guard;
    plan_run(first, last_x, m);
    @(negedge clk);
    lane_first = LW'(first); lane_end = LW'(last_x); lane_mask = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    m = '1;  // inputs after start must not matter
    lane_mask = ~lane_mask;
    guard = 0;
    while (!done && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    check(done == 1'b1, "R10", "done reached", done, 1);
    check(busy == 1'b1, "R10", "busy with done", busy, 1);
    check(fail == e_fail, "R9", "fail at done", fail, e_fail);
    check(e_idx == e_n, "R2", "transactions consumed", e_idx, e_n);
    @(negedge clk);
    check(!done && !busy, "R10", "done one cycle then idle", {done, busy}, 0);
  endtask

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    check(!busy && !done && !fail && !reg_req && !chk_req, "R1", "reset state",
          {busy, done, fail, reg_req, chk_req}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !reg_req && !chk_req, "R1", "idle without start",
          {busy, reg_req, chk_req}, 0);

    // every phase value against a checker that never passes (R5 R6 R7 R8 R9)
    for (int l = 0; l < LANES; l++) begin
      regs[l] = $urandom & ~(32'd7 << 6);
      regs[l] = regs[l] | (32'(l % 8) << 6);
      pass_at[l] = 4;
    end
    run(0, LANES, '1);

    // phase 1 with all other bits set (R6), passing on the last check on another lane
    regs[2] = 32'hFFFF_FE7F; pass_at[2] = 4;
    regs[3] = 32'h0000_0000; pass_at[3] = 3;
    run(2, 4, '1);

    // immediate passes with mask holes (R4 R2)
    for (int l = 0; l < LANES; l++) pass_at[l] = 0;
    run(2, 8, 9'b0_1010_0110);

    // empty range and range beyond the last lane (R10 R2)
    run(3, 3, '1);
    run(6, 15, '1);

    // constrained random runs
    for (int r = 0; r < 40; r++) begin
      int f;
      int e;
      for (int l = 0; l < LANES; l++) begin
        regs[l] = $urandom;
        pass_at[l] = int'($urandom % 5);
      end
      f = int'($urandom % (LANES + 1));
      e = f + int'($urandom % (LANES + 2 - f));
      run(f, e, LANES'($urandom));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R10 watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule